// File: doc/BRIEF.md
# Multi-mode barrel shift unit

This block moves an N-bit operand by a variable number of bit positions in one pass. A 3-bit operation code selects the kind of move. There are zero-filling logical shifts in both directions. A right arithmetic shift copies the sign bit into the vacated top positions. A left arithmetic shift copies the original least significant bit into the vacated bottom positions, so it does not behave like the logical left shift. Two rotates wrap the bits that leave one end back in at the other.

The datapath is a cascade of log2(N) two-way mux stages. Stage k moves the word by 2^k places when bit k of the amount is set. The result can be captured in an optional output register together with a one-cycle-delayed valid strobe. That register is enabled by default. The width N must be a power of two, and it defaults to 16.

Top module: `bshift_unit`

## Requirements
- R1: Op code 000 (logical left) moves the operand toward the MSB by the amount and puts 0 into every vacated low bit.
- R2: Op code 001 (logical right) moves the operand toward the LSB by the amount and puts 0 into every vacated high bit.
- R3: Op code 010 (arithmetic left) moves toward the MSB and fills every vacated low bit with the operand's original bit 0.
- R4: Op code 011 (arithmetic right) moves toward the LSB and fills every vacated high bit with the operand's original bit N-1.
- R5: Op code 100 (rotate left) reinserts the bits that leave the MSB end at the LSB end, so no bit is lost.
- R6: Op code 101 (rotate right) reinserts the bits that leave the LSB end at the MSB end.
- R7: An amount of 0 returns the operand unchanged for every op code.
- R8: Op codes 110 and 111 return the operand unchanged for any amount.
- R9: The result appears on out_data and out_valid exactly one rising clock edge after the request, and out_valid equals in_valid of the previous cycle.
- R10: A synchronous active-high rst clears out_valid and out_data to 0 on the next rising edge.
- R11: In a cycle with in_valid low, out_data keeps its previous value on the following edge.
- R12: A one-place logical left shift equals the lower N-1 operand bits with a 0 appended below them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | N | Operand |
| in_amt | input | clog2(N) | Number of positions to move |
| in_op | input | 3 | Operation code (000..111) |
| out_valid | output | 1 | Delayed request strobe |
| out_data | output | N | Registered result |

## Verification
The checker enforces the following on every clock. The output timing and valid alignment must hold. Data must hold when no request is made. Reset must clear both outputs. Zero-amount requests and pass-through codes must return the operand. The fill bit at the vacated end must be correct for each shift kind, and rotates must preserve the population count. The exact bit placement for every amount can only be shown by the bench's scenarios. In those scenarios, every op code is swept over all amounts with several operands and compared against a bit-at-a-time reference. Chosen operands are also used to tell a copied LSB fill apart from a zero fill.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    localparam int DEF_WIDTH = 16;

    typedef enum logic [2:0] {
        OP_SLL   = 3'b000,
        OP_SRL   = 3'b001,
        OP_SLA   = 3'b010,
        OP_SRA   = 3'b011,
        OP_ROL   = 3'b100,
        OP_ROR   = 3'b101,
        OP_PASSA = 3'b110,
        OP_PASSB = 3'b111
    } shop_e;

    typedef struct packed {
        logic left;     // direction toward MSB
        logic wrap;     // rotate: refill from the other end
        logic copy;     // arithmetic: refill with an edge bit
        logic bypass;   // pass operand through
    } shctl_t;

    function automatic shctl_t decode_op(shop_e op);
        shctl_t c;
        c = '0;
        unique case (op)
            OP_SLL:   c.left = 1'b1;
            OP_SRL:   c.left = 1'b0;
            OP_SLA:   begin c.left = 1'b1; c.copy = 1'b1; end
            OP_SRA:   c.copy = 1'b1;
            OP_ROL:   begin c.left = 1'b1; c.wrap = 1'b1; end
            OP_ROR:   c.wrap = 1'b1;
            default:  c.bypass = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
    import bshift_pkg::*;
#(
    parameter int N = DEF_WIDTH
) (
    input  shop_e          op,
    input  logic [N-1:0]   d,
    output shctl_t         ctl,
    output logic           fill_bit
);

    always_comb begin
        ctl = decode_op(op);
        if (!ctl.copy)
            fill_bit = 1'b0;
        else if (ctl.left)
            fill_bit = d[0];
        else
            fill_bit = d[N-1];
    end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
    import bshift_pkg::*;
#(
    parameter int N  = DEF_WIDTH,
    parameter int SH = 1
) (
    input  logic [N-1:0] d,
    input  shctl_t       ctl,
    input  logic         fill_bit,
    input  logic         en,
    output logic [N-1:0] q
);

    logic [SH-1:0] low_in;
    logic [SH-1:0] high_in;

    always_comb begin
        low_in  = ctl.wrap ? d[N-1:N-SH] : {SH{fill_bit}};
        high_in = ctl.wrap ? d[SH-1:0]   : {SH{fill_bit}};
        if (!en)
            q = d;
        else if (ctl.left)
            q = {d[N-1-SH:0], low_in};
        else
            q = {high_in, d[N-1:SH]};
    end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int N = DEF_WIDTH,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  din,
    input  logic [AW-1:0] amt,
    input  shop_e         op,
    output logic [N-1:0]  dout
);

    shctl_t     ctl;
    logic       fill_bit;
    logic [N-1:0] lane [AW+1];

    bshift_decode #(.N(N)) dec_i (
        .op       (op),
        .d        (din),
        .ctl      (ctl),
        .fill_bit (fill_bit)
    );

    assign lane[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        bshift_stage #(.N(N), .SH(1 << k)) stage_i (
            .d        (lane[k]),
            .ctl      (ctl),
            .fill_bit (fill_bit),
            .en       (amt[k]),
            .q        (lane[k+1])
        );
    end

    assign dout = ctl.bypass ? din : lane[AW];

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
    import bshift_pkg::*;
#(
    parameter int N       = DEF_WIDTH,
    parameter bit REG_OUT = 1'b1,
    localparam int AW     = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [N-1:0]  in_data,
    input  logic [AW-1:0] in_amt,
    input  logic [2:0]    in_op,
    output logic          out_valid,
    output logic [N-1:0]  out_data
);

    logic [N-1:0] result;

    bshift_core #(.N(N)) core_i (
        .din  (in_data),
        .amt  (in_amt),
        .op   (shop_e'(in_op)),
        .dout (result)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid)
                    out_data <= result;
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_data  = result;
    end

endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
    parameter int N       = 16,
    parameter bit REG_OUT = 1'b1,
    localparam int AW     = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [N-1:0]  in_data,
    input logic [AW-1:0] in_amt,
    input logic [2:0]    in_op,
    input logic          out_valid,
    input logic [N-1:0]  out_data
);

    if (REG_OUT) begin : g_props
        assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        assert_reset_clear_R10: assert property (@(posedge clk)
            rst |=> (!out_valid && out_data == '0));
        assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_data));
        assert_zero_amt_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_amt == '0) |=> out_data == $past(in_data));
        assert_passthru_R8: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op[2:1] == 2'b11) |=> out_data == $past(in_data));
        assert_sll_zero_R1: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == 3'b000 && in_amt != '0) |=> !out_data[0]);
        assert_srl_zero_R2: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == 3'b001 && in_amt != '0) |=> !out_data[N-1]);
        assert_sla_fill_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == 3'b010) |=> out_data[0] == $past(in_data[0]));
        assert_sra_fill_R4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == 3'b011) |=> out_data[N-1] == $past(in_data[N-1]));
        assert_rol_keep_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == 3'b100) |=> $countones(out_data) == $countones($past(in_data)));
        assert_ror_keep_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_op == 3'b101) |=> $countones(out_data) == $countones($past(in_data)));
    end

endmodule

bind bshift_unit bshift_unit_chk #(.N(N), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/bshift_unit_tb_top.sv
module bshift_unit_tb_top;

    localparam int N      = 16;
    localparam int AW     = $clog2(N);
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_data = '0;
    logic [AW-1:0] in_amt = '0;
    logic [2:0]    in_op = '0;
    logic          out_valid;
    logic [N-1:0]  out_data;

    logic          exp_valid = 1'b0;
    logic [N-1:0]  exp_data = '0;
    int            n_tests = 0;
    int            n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    bshift_unit #(.N(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_amt    (in_amt),
        .in_op     (in_op),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [N-1:0] ref_model(input logic [2:0] op,
                                               input logic [N-1:0] d,
                                               input int amt);
        logic [N-1:0] r;
        logic lsb0;
        logic msb0;
        r    = d;
        lsb0 = d[0];
        msb0 = d[N-1];
        for (int i = 0; i < amt; i++) begin
            case (op)
                3'd0: r = {r[N-2:0], 1'b0};
                3'd1: r = {1'b0, r[N-1:1]};
                3'd2: r = {r[N-2:0], lsb0};
                3'd3: r = {msb0, r[N-1:1]};
                3'd4: r = {r[N-2:0], r[N-1]};
                3'd5: r = {r[0], r[N-1:1]};
                default: r = r;
            endcase
        end
        return r;
    endfunction

    function automatic string op_tag(input logic [2:0] op, input int amt);
        if (op[2:1] == 2'b11) return "R8";
        if (amt == 0) return "R7";
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [N-1:0] d, input logic [AW-1:0] a,
                        input logic [2:0] op, input string req);
        in_valid = v;
        in_data  = d;
        in_amt   = a;
        in_op    = op;
        @(posedge clk);
        if (rst) begin
            exp_valid = 1'b0;
            exp_data  = '0;
        end else begin
            exp_valid = v;
            if (v) exp_data = ref_model(op, d, int'(a));
        end
        @(negedge clk);
        check(req, out_data, exp_data);
        check("R9", {{(N-1){1'b0}}, out_valid}, {{(N-1){1'b0}}, exp_valid});
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] ops [4];
        ops[0] = 16'h8001;
        ops[1] = 16'h7FFE;
        ops[2] = 16'hA5C3;
        ops[3] = 16'h1234;

        // R10: reset with a live request clears both outputs
        @(negedge clk);
        step(1'b1, 16'hFFFF, 4'd3, 3'd4, "R10");
        rst = 1'b0;

        // sweep every op code over every amount
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < N; a++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [N-1:0] d;
                    d = (k < 4) ? ops[k] : N'($urandom);
                    step(1'b1, d, AW'(a), 3'(op), op_tag(3'(op), a));
                end
            end
        end

        // R3: LSB copy differs from zero fill
        step(1'b1, 16'h0001, 4'd4, 3'd2, "R3");
        check("R3", out_data, 16'h001F);
        // R4: sign copy
        step(1'b1, 16'h8000, 4'd15, 3'd3, "R4");
        check("R4", out_data, 16'hFFFF);
        // R12: single-place logical left
        step(1'b1, 16'hC3A5, 4'd1, 3'd0, "R12");
        check("R12", out_data, {16'hC3A5 & 16'h7FFF, 1'b0} >> 0 & 16'hFFFF);
        check("R12", out_data, 16'h874A);

        // R11: idle cycles keep the last result
        for (int i = 0; i < 5; i++)
            step(1'b0, N'($urandom), AW'($urandom), 3'($urandom), "R11");
        check("R11", out_data, 16'h874A);

        // R10: mid-run reset
        rst = 1'b1;
        step(1'b1, 16'h5555, 4'd2, 3'd0, "R10");
        rst = 1'b0;
        step(1'b0, 16'h0, 4'd0, 3'd0, "R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule